// File: doc/BRIEF.md
# H-Bridge Command Decoder with Fault Latching

This block sits between a motor controller's two digital command lines and the gate drivers of a full bridge built from two half-bridge legs. A direction line picks the rotation sense. A modulation line chops the bridge between driving and braking. The block turns these into a high-side enable and a low-side enable for each leg. It never lets the two switches of one leg conduct together, and it puts one idle cycle between them whenever a leg changes side.

The block also watches five comparator bits: over-current, over-temperature, supply too low, supply too high, and load-current anomaly. Over-current counts only after a qualification window. Over-current and over-temperature shut the bridge and latch it off. Supply-too-high also latches the bridge off, but without raising any flag. Supply-too-low shuts the bridge only while it lasts. A load-current anomaly that persists raises the flags and leaves the switches running. The latched conditions clear when either command line changes level; reset is not needed.

Two active-low flags report faults. The pulse flag is stretched to a minimum width so it suits a wired-OR line. The hold flag stays low until a command line changes.

A five-state machine governs the bridge:
- RUN: the bridge is driven normally.
- UVLO: the supply is too low.
- OV_ACTIVE: the supply is too high.
- OV_WAIT: the high supply has gone and the bridge waits for a command change.
- TRIP: a flagged latch-off is in force.

The transitions are:
- RUN goes to UVLO when the supply is low. This check has first priority.
- RUN goes to OV_ACTIVE when the supply is high. This check has second priority.
- RUN goes to TRIP on a qualified over-current or on over-temperature.
- UVLO returns to RUN when the supply recovers.
- OV_ACTIVE goes to OV_WAIT when the high supply clears.
- OV_WAIT goes to RUN on a command edge.
- TRIP goes to RUN on a command edge.

Top module: `hbridge_ctrl`

## Requirements
- R1: With the modulation input low and the block in RUN, both legs settle to high side on and low side off (brake), whatever the direction input. In the packed view {hs_en_o[1:0], ls_en_o[1:0]} this is 4'b1100.
- R2: With the modulation input high, direction 0 drives leg 0 high and leg 1 low (4'b0110), and direction 1 drives leg 0 low and leg 1 high (4'b1001). Both take effect one cycle after the inputs change, unless R3 inserts a gap.
- R3: A leg never has both enables high in the same cycle. When a leg moves from one side to the other, it spends exactly one cycle with both enables low.
- R4: The over-current input is ignored unless it stays high for OC_CYC consecutive cycles (OC_US microseconds, 10 cycles by default). After qualification, the enables drop two cycles later.
- R5: A qualified over-current, or over-temperature high for one cycle, turns all four enables off two cycles later and drives both flags low. Both stay that way after the fault input falls.
- R6: After a latch-off from R5 or R8, a level change on the direction or modulation input re-enters RUN. The commanded drive appears two cycles after the edge.
- R7: Supply-too-low turns all enables off two cycles after it rises and leaves both flags high. Drive resumes on its own two cycles after it falls, with no command edge needed.
- R8: Supply-too-high turns all enables off and raises no flag. Command edges made while it is high are ignored. After it clears, the bridge stays off until a later command edge.
- R9: A load-anomaly input held high for OL_CYC consecutive cycles (1000 by default) drives both flags low one cycle later. The enables are unaffected.
- R10: The pulse flag stays low while its source (TRIP state or qualified load anomaly) is active, and for PULSE_CYC-1 further cycles after it ends (PULSE_CYC is 3 by default). A one-cycle source therefore gives exactly PULSE_CYC low cycles.
- R11: The hold flag stays low after its source ends, until a command edge occurs. A command edge does not clear it while the load anomaly is still qualified.
- R12: During reset all enables are low and both flags are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dir_i | input | 1 | Rotation direction command |
| pwm_i | input | 1 | Modulation command, 0 brakes |
| oc_i | input | 1 | Over-current comparator |
| ot_i | input | 1 | Over-temperature comparator |
| uv_i | input | 1 | Supply-too-low comparator |
| ov_i | input | 1 | Supply-too-high comparator |
| ol_i | input | 1 | Load-current anomaly comparator |
| hs_en_o | output | 2 | High-side enable per leg |
| ls_en_o | output | 2 | Low-side enable per leg |
| flag_pulse_n_o | output | 1 | Stretched active-low fault flag |
| flag_hold_n_o | output | 1 | Latched active-low fault flag |

## Verification
Command inputs reach the enables one cycle later, or two cycles later when a leg must pass through its idle gap. Unfiltered faults (over-temperature and the two supply conditions) reach the enables two cycles after they rise: one cycle for the state register and one for the leg register. A persistent over-current is still driving at OC_CYC+1 cycles and is off at OC_CYC+2. The flags follow the state one cycle later, so the load-anomaly flags fall at OL_CYC+1 cycles. The bench drives inputs on falling edges and samples after an exact number of rising edges computed from these counts. It checks both sides of each boundary: the last cycle before a change and the first cycle after it.

// File: rtl/hbc_pkg.sv
package hbc_pkg;

    typedef enum logic [2:0] {
        ST_RUN       = 3'd0,
        ST_UVLO      = 3'd1,
        ST_OV_ACTIVE = 3'd2,
        ST_OV_WAIT   = 3'd3,
        ST_TRIP      = 3'd4
    } hb_state_e;

    typedef enum logic [1:0] {
        LEG_OFF  = 2'b00,
        LEG_HIGH = 2'b01,
        LEG_LOW  = 2'b10
    } leg_cmd_e;

endpackage

// File: rtl/hbc_persist.sv
module hbc_persist #(
    parameter int N = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_i,
    output logic qual_o
);
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(N - 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(N);

    logic [CW-1:0] cnt_q;
    logic          qual_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else if (!in_i) begin
            cnt_q  <= '0;
            qual_q <= 1'b0;
        end else begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + 1'b1;
            end
            qual_q <= qual_q | (cnt_q == CNT_LAST);
        end
    end

    assign qual_o = qual_q;

    AST_QUAL_NEEDS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        qual_q |-> $past(in_i)) else $error("qualified without input"); // R4

    AST_QUAL_AFTER_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(qual_q) |-> (cnt_q == CNT_MAX)) else $error("qualified early"); // R4

endmodule

// File: rtl/hbc_leg.sv
module hbc_leg
    import hbc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  leg_cmd_e cmd_i,
    output logic     hs_o,
    output logic     ls_o
);
    logic hs_q, ls_q;
    logic want_hs, want_ls;

    assign want_hs = (cmd_i == LEG_HIGH);
    assign want_ls = (cmd_i == LEG_LOW);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hs_q <= 1'b0;
            ls_q <= 1'b0;
        end else if ((want_hs && ls_q) || (want_ls && hs_q)) begin
            hs_q <= 1'b0;
            ls_q <= 1'b0;
        end else begin
            hs_q <= want_hs;
            ls_q <= want_ls;
        end
    end

    assign hs_o = hs_q;
    assign ls_o = ls_q;

    AST_LEG_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_q && ls_q)) else $error("both switches of a leg on"); // R3

    AST_GAP_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
        hs_q |=> !ls_q) else $error("no gap high to low"); // R3

    AST_GAP_AFTER_LS: assert property (@(posedge clk) disable iff (!rst_n)
        ls_q |=> !hs_q) else $error("no gap low to high"); // R3

endmodule

// File: rtl/hbc_status.sv
module hbc_status #(
    parameter int PULSE_CYC = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic src_i,
    input  logic set_i,
    input  logic clr_i,
    output logic pulse_n_o,
    output logic hold_n_o
);
    localparam int PW = $clog2(PULSE_CYC + 1);
    localparam logic [PW-1:0] RELOAD = PW'(PULSE_CYC - 1);
    localparam logic [PW-1:0] PMAX   = PW'(PULSE_CYC);

    logic [PW-1:0] cnt_q;
    logic          act_q;
    logic          hold_q;
    logic [PW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            act_q <= 1'b0;
        end else begin
            if (src_i) begin
                cnt_q <= RELOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
            act_q <= src_i | (cnt_q != '0);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q <= 1'b0;
        end else begin
            hold_q <= set_i | (hold_q & ~clr_i);
        end
    end

    assign pulse_n_o = ~act_q;
    assign hold_n_o  = ~hold_q;

    // width checker for the stretched flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= '0;
        end else if (act_q) begin
            if (run_q != PMAX) run_q <= run_q + 1'b1;
        end else begin
            run_q <= '0;
        end
    end

    AST_PULSE_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(act_q) |-> (run_q == PMAX)) else $error("pulse flag too short"); // R10

    AST_HOLD_NEEDS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hold_q) |-> $past(set_i)) else $error("hold flag without cause"); // R11

endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hbc_pkg::*;
#(
    parameter int CLK_HZ   = 1_000_000,
    parameter int OC_US    = 10,
    parameter int OL_US    = 1000,
    parameter int PULSE_US = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       dir_i,
    input  logic       pwm_i,
    input  logic       oc_i,
    input  logic       ot_i,
    input  logic       uv_i,
    input  logic       ov_i,
    input  logic       ol_i,
    output logic [1:0] hs_en_o,
    output logic [1:0] ls_en_o,
    output logic       flag_pulse_n_o,
    output logic       flag_hold_n_o
);
    localparam int CYC_PER_US = (CLK_HZ / 1_000_000 < 1) ? 1 : CLK_HZ / 1_000_000;
    localparam int OC_CYC     = (OC_US * CYC_PER_US < 1) ? 1 : OC_US * CYC_PER_US;
    localparam int OL_CYC     = (OL_US * CYC_PER_US < 1) ? 1 : OL_US * CYC_PER_US;
    localparam int PULSE_CYC  = (PULSE_US * CYC_PER_US < 1) ? 1 : PULSE_US * CYC_PER_US;
    localparam int NUM_LEGS   = 2;

    hb_state_e state_q, state_d;
    logic      dir_q, pwm_q;
    logic      toggle;
    logic      oc_q, ol_q;
    leg_cmd_e  leg_cmd [NUM_LEGS];
    logic      trip_src;

    // command edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= 1'b0;
            pwm_q <= 1'b0;
        end else begin
            dir_q <= dir_i;
            pwm_q <= pwm_i;
        end
    end

    assign toggle = (dir_i ^ dir_q) | (pwm_i ^ pwm_q);

    hbc_persist #(.N(OC_CYC)) u_oc_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   (oc_i),
        .qual_o (oc_q)
    );

    hbc_persist #(.N(OL_CYC)) u_ol_filt (
        .clk    (clk),
        .rst_n  (rst_n),
        .in_i   (ol_i),
        .qual_o (ol_q)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN: begin
                if (uv_i)              state_d = ST_UVLO;
                else if (ov_i)         state_d = ST_OV_ACTIVE;
                else if (oc_q || ot_i) state_d = ST_TRIP;
            end
            ST_UVLO: begin
                if (!uv_i) state_d = ST_RUN;
            end
            ST_OV_ACTIVE: begin
                if (!ov_i) state_d = ST_OV_WAIT;
            end
            ST_OV_WAIT: begin
                if (toggle) state_d = ST_RUN;
            end
            ST_TRIP: begin
                if (toggle) state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    // leg commands
    always_comb begin
        for (int k = 0; k < NUM_LEGS; k++) leg_cmd[k] = LEG_OFF;
        if (state_q == ST_RUN) begin
            if (!pwm_i) begin
                leg_cmd[0] = LEG_HIGH;
                leg_cmd[1] = LEG_HIGH;
            end else if (!dir_i) begin
                leg_cmd[0] = LEG_HIGH;
                leg_cmd[1] = LEG_LOW;
            end else begin
                leg_cmd[0] = LEG_LOW;
                leg_cmd[1] = LEG_HIGH;
            end
        end
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hbc_leg u_leg (
            .clk   (clk),
            .rst_n (rst_n),
            .cmd_i (leg_cmd[g]),
            .hs_o  (hs_en_o[g]),
            .ls_o  (ls_en_o[g])
        );
    end

    assign trip_src = (state_q == ST_TRIP);

    hbc_status #(.PULSE_CYC(PULSE_CYC)) u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_i     (trip_src | ol_q),
        .set_i     (ol_q | (trip_src & ~toggle)),
        .clr_i     (toggle),
        .pulse_n_o (flag_pulse_n_o),
        .hold_n_o  (flag_hold_n_o)
    );

    AST_TRIP_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TRIP) |=> (hs_en_o == 2'b00 && ls_en_o == 2'b00))
        else $error("drive during trip"); // R5

    AST_OV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OV_ACTIVE || state_q == ST_OV_WAIT) |=> (hs_en_o == 2'b00 && ls_en_o == 2'b00))
        else $error("drive during over-voltage hold"); // R8

    AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UVLO) |=> (hs_en_o == 2'b00 && ls_en_o == 2'b00))
        else $error("drive during under-voltage"); // R7

    AST_UV_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UVLO && !ol_q && $past(state_q == ST_UVLO)) |=> flag_pulse_n_o)
        else $error("flag raised by under-voltage"); // R7

endmodule

// File: tb/hbridge_ctrl_tb.sv
module hbridge_ctrl_tb;

    localparam int OC_CYC    = 10;
    localparam int OL_CYC    = 1000;
    localparam int PULSE_CYC = 3;
    localparam int WATCHDOG  = 200000;

    localparam logic [3:0] V_BRAKE = 4'b1100;
    localparam logic [3:0] V_DIR0  = 4'b0110;
    localparam logic [3:0] V_DIR1  = 4'b1001;
    localparam logic [3:0] V_OFF   = 4'b0000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       dir_i = 1'b0, pwm_i = 1'b0;
    logic       oc_i = 1'b0, ot_i = 1'b0, uv_i = 1'b0, ov_i = 1'b0, ol_i = 1'b0;
    logic [1:0] hs_en_o, ls_en_o;
    logic       flag_pulse_n_o, flag_hold_n_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    hbridge_ctrl #(
        .CLK_HZ(1_000_000), .OC_US(10), .OL_US(1000), .PULSE_US(3)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .dir_i(dir_i), .pwm_i(pwm_i),
        .oc_i(oc_i), .ot_i(ot_i), .uv_i(uv_i), .ov_i(ov_i), .ol_i(ol_i),
        .hs_en_o(hs_en_o), .ls_en_o(ls_en_o),
        .flag_pulse_n_o(flag_pulse_n_o), .flag_hold_n_o(flag_hold_n_o)
    );

    function automatic logic [3:0] drive_view();
        return {hs_en_o, ls_en_o};
    endfunction

    function automatic logic [1:0] flag_view();
        return {flag_pulse_n_o, flag_hold_n_o};
    endfunction

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        step(3);
        check("R12 enables in reset", drive_view(), V_OFF);
        check("R12 flags in reset", flag_view(), 2'b11);
        rst_n = 1'b1;
        step(2);
        check("R1 brake after reset", drive_view(), V_BRAKE);
    endtask

    task automatic t_direction();
        pwm_i = 1'b1; dir_i = 1'b0;
        step(1);
        check("R3 leg1 gap", drive_view(), 4'b0100);
        step(1);
        check("R2 direction 0", drive_view(), V_DIR0);
        dir_i = 1'b1;
        step(1);
        check("R3 both legs gap", drive_view(), V_OFF);
        step(1);
        check("R2 direction 1", drive_view(), V_DIR1);
        pwm_i = 1'b0;
        step(1);
        check("R3 leg0 gap to brake", drive_view(), 4'b1000);
        step(1);
        check("R1 brake with dir 1", drive_view(), V_BRAKE);
        check("R1 flags idle", flag_view(), 2'b11);
    endtask

    task automatic t_oc_glitch();
        oc_i = 1'b1;
        step(OC_CYC - 1);
        oc_i = 1'b0;
        step(5);
        check("R4 short over-current ignored", drive_view(), V_BRAKE);
        check("R4 short over-current no flag", flag_view(), 2'b11);
    endtask

    task automatic t_oc_trip();
        oc_i = 1'b1;
        step(OC_CYC + 1);
        check("R4 drive before trip", drive_view(), V_BRAKE);
        step(1);
        check("R5 over-current off", drive_view(), V_OFF);
        check("R5 over-current flags", flag_view(), 2'b00);
        oc_i = 1'b0;
        step(10);
        check("R5 stays off", drive_view(), V_OFF);
        check("R5 flags stay", flag_view(), 2'b00);
        pwm_i = 1'b1; dir_i = 1'b1;
        step(1);
        check("R6 off on edge cycle", drive_view(), V_OFF);
        check("R11 hold cleared by edge", flag_pulse_n_o == 1'b0 && flag_hold_n_o == 1'b1, 1);
        step(1);
        check("R6 drive restored", drive_view(), V_DIR1);
        step(PULSE_CYC);
        check("R10 pulse flag released", flag_pulse_n_o, 1);
    endtask

    task automatic t_ot_trip();
        ot_i = 1'b1;
        step(1);
        ot_i = 1'b0;
        step(1);
        check("R5 over-temperature off", drive_view(), V_OFF);
        check("R5 over-temperature flags", flag_view(), 2'b00);
        step(5);
        check("R5 over-temperature latched", drive_view(), V_OFF);
        dir_i = 1'b0;
        step(2 + PULSE_CYC);
        check("R6 drive after over-temperature", drive_view(), V_DIR0);
        check("R6 flags idle after recovery", flag_view(), 2'b11);
    endtask

    task automatic t_uv();
        uv_i = 1'b1;
        step(2);
        check("R7 under-voltage off", drive_view(), V_OFF);
        check("R7 under-voltage no flags", flag_view(), 2'b11);
        step(5);
        check("R7 still off", drive_view(), V_OFF);
        uv_i = 1'b0;
        step(2);
        check("R7 automatic resume", drive_view(), V_DIR0);
        check("R7 flags stay idle", flag_view(), 2'b11);
    endtask

    task automatic t_ov();
        ov_i = 1'b1;
        step(2);
        check("R8 over-voltage off", drive_view(), V_OFF);
        check("R8 over-voltage no flags", flag_view(), 2'b11);
        pwm_i = 1'b0;
        step(2);
        ov_i = 1'b0;
        step(3);
        check("R8 edge during over-voltage ignored", drive_view(), V_OFF);
        pwm_i = 1'b1;
        step(2);
        check("R8 drive after later edge", drive_view(), V_DIR0);
        check("R8 flags idle", flag_view(), 2'b11);
    endtask

    task automatic t_ol();
        ol_i = 1'b1;
        step(OL_CYC);
        check("R9 flags not yet", flag_view(), 2'b11);
        step(1);
        check("R9 load anomaly flags", flag_view(), 2'b00);
        check("R9 drive unaffected", drive_view(), V_DIR0);
        dir_i = 1'b1;
        step(3);
        check("R11 hold kept while anomaly", flag_hold_n_o, 0);
        check("R9 drive follows command", drive_view(), V_DIR1);
        ol_i = 1'b0;
        step(1 + PULSE_CYC + 1);
        check("R10 pulse flag released after anomaly", flag_pulse_n_o, 1);
        check("R11 hold flag persists", flag_hold_n_o, 0);
        dir_i = 1'b0;
        step(1);
        check("R11 hold flag cleared by edge", flag_hold_n_o, 1);
    endtask

    task automatic t_pulse();
        int low_cnt = 0;
        ol_i = 1'b1;
        step(OL_CYC);
        ol_i = 1'b0;
        for (int i = 0; i < 20; i++) begin
            step(1);
            if (!flag_pulse_n_o) low_cnt++;
        end
        check("R10 one-cycle source width", low_cnt, PULSE_CYC);
        check("R11 hold flag set by short source", flag_hold_n_o, 0);
        pwm_i = 1'b0;
        step(2);
        check("R11 hold cleared", flag_hold_n_o, 1);
        check("R1 brake at end", drive_view(), V_BRAKE);
    endtask

    initial begin
        t_reset();
        t_direction();
        t_oc_glitch();
        t_oc_trip();
        t_ot_trip();
        t_uv();
        t_ov();
        t_ol();
        t_pulse();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < WATCHDOG; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule